// File: doc/BRIEF.md
# Full-Speed IN Transaction Engine

This block is the device-side controller that answers host IN transactions on a full-speed serial bus link. It watches the fields that an upstream receive decoder has already pulled out of each packet. When an IN token arrives for this device and names an endpoint that is implemented and enabled, the engine chooses a reply. The reply is a data packet, a STALL handshake or a NAK handshake. The engine then tells the transmitter which PID to send and supplies the payload by stepping a byte address while the transmitter requests bytes.

After a data packet on a non-isochronous endpoint, the engine waits a bounded turnaround window for the host's ACK. It keeps one data-toggle bit per endpoint, and that bit selects DATA0 or DATA1. A SETUP token clears the toggle, an accepted ACK advances it, and a software write port may overwrite all toggles at once. Each accepted ACK also produces a one-cycle release pulse for that endpoint, so its transmit buffer can be freed.

Top module: `fs_in_engine`

## Requirements
- R1: A token is accepted only in a cycle where the receive packet-end and packet-valid strobes are both high, the PID's low two bits are 01 (token type), and the received address equals `dev_addr`. Any other packet draws no reply.
- R2: A reply is started only for an IN token (PID 1001) that names an endpoint whose `ep_enabled` bit is set. OUT tokens and IN tokens to disabled endpoints leave `tx_start` low.
- R3: An endpoint number at or above NUM_EP is treated as absent. An IN token to it draws no reply, and a SETUP token to it changes no toggle.
- R4: Two cycles after the accepted IN token, `tx_start` pulses for one cycle and `tx_pid` carries the reply. An isochronous endpoint always gets a data PID, even when stalled. A stalled endpoint otherwise gets STALL (1110), an endpoint with data ready gets a data PID, and any other endpoint gets NAK (1010).
- R5: The data PID is DATA0 (0011) when the endpoint's toggle is 0 and DATA1 (1011) when it is 1.
- R6: `buf_addr` is 0 when idle and rises by one for each `tx_data_get` while payload is being sent.
- R7: The payload ends when the endpoint's `ep_data_done` bit is high, or when a byte is requested at the all-ones byte address. After that, `tx_data_avail` is low and further requests do not move `buf_addr`.
- R8: After `tx_pkt_end` of a data packet, the engine waits TURN_CYCLES cycles for a receive packet start. If none comes, it returns to idle, and a later ACK has no effect.
- R9: An ACK accepted in the handshake window flips that endpoint's toggle. One cycle later, `in_sent` pulses high for exactly one cycle on that endpoint's bit only.
- R10: After a NAK, a STALL or an isochronous data packet, the engine expects no handshake. An ACK that follows changes no toggle and raises no `in_sent`.
- R11: A SETUP token (PID 1101) to an active endpoint clears its toggle. A `tog_we` write loads all toggles from `tog_wdata` and takes priority over a SETUP clear or an ACK flip in the same cycle.
- R12: `link_reset`, or a low `link_active`, returns the engine to idle at once. `link_reset` also clears every toggle.
- R13: A new IN token that arrives while the engine waits for the ACK starts a fresh reply. Because the toggle has not advanced, that reply carries the same data PID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_reset | input | 1 | Bus reset in progress |
| link_active | input | 1 | Link is up |
| dev_addr | input | 7 | Programmed device address |
| rx_pkt_start | input | 1 | Receive packet start strobe |
| rx_pkt_end | input | 1 | Receive packet end strobe |
| rx_pkt_valid | input | 1 | Received packet passed its checks |
| rx_pid | input | 4 | Received PID |
| rx_addr | input | 7 | Received token address |
| rx_endp | input | 4 | Received token endpoint |
| ep_enabled | input | NUM_EP | Endpoint IN enables |
| ep_stall | input | NUM_EP | Endpoint stalled |
| ep_iso | input | NUM_EP | Endpoint is isochronous |
| ep_has_data | input | NUM_EP | Endpoint has a packet ready |
| ep_data_done | input | NUM_EP | All payload bytes handed over |
| tx_data_get | input | 1 | Transmitter takes one byte |
| tx_pkt_end | input | 1 | Transmitter finished the packet |
| tx_start | output | 1 | Start-of-reply pulse |
| tx_pid | output | 4 | PID of the reply |
| tx_data_avail | output | 1 | Payload bytes remain |
| buf_ep | output | log2(NUM_EP) | Endpoint being served |
| buf_addr | output | BYTE_AW | Payload byte address |
| tog_we | input | 1 | Toggle overwrite enable |
| tog_wdata | input | NUM_EP | Toggle overwrite value |
| tog_q | output | NUM_EP | Current data toggles |
| in_sent | output | NUM_EP | Per-endpoint ACK-accepted pulse |

## Verification
The toggle bit of one endpoint can be targeted in the same clock cycle by the ACK flip and by the software overwrite. The same holds for the SETUP clear and the overwrite. The bench raises `tog_we` in exactly the cycle that carries the ACK end strobe. It then expects the written value rather than the flipped one, while `in_sent` still pulses. The SETUP clear is judged separately against a freshly written all-ones pattern, and only the addressed endpoint's bit may drop.

// File: rtl/fs_in_pkg.sv
package fs_in_pkg;

    localparam int DEV_AW = 7;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_GOT_IN   = 3'd1,
        ST_PAYLOAD  = 3'd2,
        ST_TX_DRAIN = 3'd3,
        ST_HS_WAIT  = 3'd4,
        ST_HS_RECV  = 3'd5
    } xact_st_e;

    localparam logic [3:0] PID_OUT   = 4'b0001;
    localparam logic [3:0] PID_IN    = 4'b1001;
    localparam logic [3:0] PID_SETUP = 4'b1101;
    localparam logic [3:0] PID_ACK   = 4'b0010;
    localparam logic [3:0] PID_NAK   = 4'b1010;
    localparam logic [3:0] PID_STALL = 4'b1110;
    localparam logic [3:0] PID_DATA0 = 4'b0011;
    localparam logic [3:0] PID_DATA1 = 4'b1011;

    // Qualified receive events for one cycle
    typedef struct packed {
        logic in_tok;   // IN token for this device
        logic ack;      // complete valid ACK packet
        logic active;   // named endpoint exists and is enabled
    } rx_evt_t;

    function automatic logic pid_is_token(input logic [3:0] pid);
        return pid[1:0] == 2'b01;
    endfunction

    function automatic logic [3:0] data_pid(input logic tog);
        return tog ? PID_DATA1 : PID_DATA0;
    endfunction

endpackage

// File: rtl/fs_in_rx_decode.sv
module fs_in_rx_decode
    import fs_in_pkg::*;
#(
    parameter int NUM_EP   = 4,
    parameter int EP_IDX_W = 2
) (
    input  logic                     rx_pkt_end,
    input  logic                     rx_pkt_valid,
    input  logic [3:0]               rx_pid,
    input  logic [DEV_AW-1:0]        rx_addr,
    input  logic [3:0]               rx_endp,
    input  logic [DEV_AW-1:0]        dev_addr,
    input  logic [NUM_EP-1:0]        ep_enabled,
    output rx_evt_t                  evt,
    output logic                     setup_hit,
    output logic [EP_IDX_W-1:0]      idx_d
);

    logic tok_ok;
    logic in_hw;

    always_comb begin
        tok_ok = rx_pkt_end && rx_pkt_valid && pid_is_token(rx_pid)
                 && (rx_addr == dev_addr);
        in_hw  = int'(rx_endp) < NUM_EP;
        idx_d  = in_hw ? rx_endp[EP_IDX_W-1:0] : '0;
        evt.in_tok = tok_ok && (rx_pid == PID_IN);
        evt.ack    = rx_pkt_end && rx_pkt_valid && (rx_pid == PID_ACK);
        evt.active = in_hw && ep_enabled[idx_d];
        setup_hit  = tok_ok && (rx_pid == PID_SETUP) && evt.active;
    end

endmodule

// File: rtl/fs_in_xact_ctrl.sv
module fs_in_xact_ctrl
    import fs_in_pkg::*;
#(
    parameter int NUM_EP      = 4,
    parameter int EP_IDX_W    = 2,
    parameter int BYTE_AW     = 9,
    parameter int TURN_CYCLES = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                link_kill,
    input  rx_evt_t             evt,
    input  logic [EP_IDX_W-1:0] idx_d,
    input  logic                rx_pkt_start,
    input  logic                rx_pkt_end,
    input  logic [NUM_EP-1:0]   ep_stall,
    input  logic [NUM_EP-1:0]   ep_iso,
    input  logic [NUM_EP-1:0]   ep_has_data,
    input  logic [NUM_EP-1:0]   ep_data_done,
    input  logic [NUM_EP-1:0]   tog_q,
    input  logic                tx_data_get,
    input  logic                tx_pkt_end,
    output xact_st_e            st,
    output logic [EP_IDX_W-1:0] ep_idx,
    output logic [BYTE_AW-1:0]  buf_addr,
    output logic                tx_start,
    output logic [3:0]          tx_pid,
    output logic                tx_data_avail,
    output logic                ack_take
);

    localparam int CNT_W = $clog2(TURN_CYCLES + 1);

    xact_st_e           st_n;
    logic               has_data_q;
    logic               need_hs, need_hs_n;
    logic [CNT_W-1:0]   cnt;
    logic               load_cnt;
    logic               start_n;
    logic [3:0]         pid_n;
    logic               more;
    logic               capture;

    assign more      = has_data_q & ~ep_data_done[ep_idx];
    assign capture   = evt.in_tok && (st == ST_IDLE || st == ST_HS_RECV);
    assign ack_take  = (st == ST_HS_RECV) && evt.ack && !link_kill;
    assign tx_data_avail = (st == ST_PAYLOAD) && more;

    always_comb begin
        st_n      = st;
        load_cnt  = 1'b0;
        start_n   = 1'b0;
        pid_n     = tx_pid;
        need_hs_n = need_hs;
        case (st)
            ST_IDLE: begin
                if (evt.in_tok && evt.active) st_n = ST_GOT_IN;
            end
            ST_GOT_IN: begin
                start_n = 1'b1;
                if (ep_iso[ep_idx]) begin
                    st_n      = ST_PAYLOAD;
                    pid_n     = data_pid(tog_q[ep_idx]);
                    need_hs_n = 1'b0;
                end else if (ep_stall[ep_idx]) begin
                    st_n      = ST_TX_DRAIN;
                    pid_n     = PID_STALL;
                    need_hs_n = 1'b0;
                end else if (has_data_q) begin
                    st_n      = ST_PAYLOAD;
                    pid_n     = data_pid(tog_q[ep_idx]);
                    need_hs_n = 1'b1;
                end else begin
                    st_n      = ST_TX_DRAIN;
                    pid_n     = PID_NAK;
                    need_hs_n = 1'b0;
                end
            end
            ST_PAYLOAD: begin
                if (!more || ((&buf_addr) && tx_data_get)) st_n = ST_TX_DRAIN;
            end
            ST_TX_DRAIN: begin
                if (tx_pkt_end) begin
                    if (need_hs) begin
                        st_n     = ST_HS_WAIT;
                        load_cnt = 1'b1;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end
            end
            ST_HS_WAIT: begin
                if (rx_pkt_start)     st_n = ST_HS_RECV;
                else if (cnt == '0)   st_n = ST_IDLE;
            end
            ST_HS_RECV: begin
                if (evt.ack)          st_n = ST_IDLE;
                else if (evt.in_tok)  st_n = evt.active ? ST_GOT_IN : ST_IDLE;
                else if (rx_pkt_end)  st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
        if (link_kill) st_n = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            need_hs  <= 1'b0;
            tx_start <= 1'b0;
            tx_pid   <= PID_NAK;
        end else begin
            st       <= st_n;
            need_hs  <= need_hs_n;
            tx_start <= start_n && !link_kill;
            tx_pid   <= pid_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ep_idx     <= '0;
            has_data_q <= 1'b0;
        end else if (capture) begin
            ep_idx     <= idx_d;
            has_data_q <= ep_has_data[idx_d];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || st == ST_IDLE) begin
            buf_addr <= '0;
        end else if (st == ST_PAYLOAD && tx_data_get) begin
            buf_addr <= buf_addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load_cnt) begin
            cnt <= CNT_W'(TURN_CYCLES);
        end else if (st == ST_HS_WAIT && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/fs_in_toggle_bank.sv
module fs_in_toggle_bank #(
    parameter int NUM_EP   = 4,
    parameter int EP_IDX_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                link_reset,
    input  logic                setup_hit,
    input  logic [EP_IDX_W-1:0] setup_idx,
    input  logic                ack_take,
    input  logic [EP_IDX_W-1:0] ack_idx,
    input  logic                tog_we,
    input  logic [NUM_EP-1:0]   tog_wdata,
    output logic [NUM_EP-1:0]   tog_q,
    output logic [NUM_EP-1:0]   in_sent
);

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        logic t_q;
        logic s_q;
        logic hit_setup;
        logic hit_ack;

        assign hit_setup = setup_hit && (setup_idx == EP_IDX_W'(e));
        assign hit_ack   = ack_take && (ack_idx == EP_IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst || link_reset)  t_q <= 1'b0;
            else if (tog_we)        t_q <= tog_wdata[e];
            else if (hit_setup)     t_q <= 1'b0;
            else if (hit_ack)       t_q <= ~t_q;
        end

        always_ff @(posedge clk) begin
            if (rst) s_q <= 1'b0;
            else     s_q <= hit_ack;
        end

        assign tog_q[e]   = t_q;
        assign in_sent[e] = s_q;
    end

endmodule

// File: rtl/fs_in_engine.sv
module fs_in_engine
    import fs_in_pkg::*;
#(
    parameter int NUM_EP      = 4,
    parameter int BYTE_AW     = 9,
    parameter int TURN_CYCLES = 64,
    localparam int EP_IDX_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                link_reset,
    input  logic                link_active,
    input  logic [6:0]          dev_addr,
    input  logic                rx_pkt_start,
    input  logic                rx_pkt_end,
    input  logic                rx_pkt_valid,
    input  logic [3:0]          rx_pid,
    input  logic [6:0]          rx_addr,
    input  logic [3:0]          rx_endp,
    input  logic [NUM_EP-1:0]   ep_enabled,
    input  logic [NUM_EP-1:0]   ep_stall,
    input  logic [NUM_EP-1:0]   ep_iso,
    input  logic [NUM_EP-1:0]   ep_has_data,
    input  logic [NUM_EP-1:0]   ep_data_done,
    input  logic                tx_data_get,
    input  logic                tx_pkt_end,
    output logic                tx_start,
    output logic [3:0]          tx_pid,
    output logic                tx_data_avail,
    output logic [EP_IDX_W-1:0] buf_ep,
    output logic [BYTE_AW-1:0]  buf_addr,
    input  logic                tog_we,
    input  logic [NUM_EP-1:0]   tog_wdata,
    output logic [NUM_EP-1:0]   tog_q,
    output logic [NUM_EP-1:0]   in_sent
);

    rx_evt_t             evt;
    logic                setup_hit;
    logic [EP_IDX_W-1:0] idx_d;
    logic                link_kill;
    logic                ack_take;
    xact_st_e            st;

    assign link_kill = link_reset || !link_active;

    fs_in_rx_decode #(.NUM_EP(NUM_EP), .EP_IDX_W(EP_IDX_W)) u_dec (
        .rx_pkt_end   (rx_pkt_end),
        .rx_pkt_valid (rx_pkt_valid),
        .rx_pid       (rx_pid),
        .rx_addr      (rx_addr),
        .rx_endp      (rx_endp),
        .dev_addr     (dev_addr),
        .ep_enabled   (ep_enabled),
        .evt          (evt),
        .setup_hit    (setup_hit),
        .idx_d        (idx_d)
    );

    fs_in_xact_ctrl #(
        .NUM_EP(NUM_EP), .EP_IDX_W(EP_IDX_W),
        .BYTE_AW(BYTE_AW), .TURN_CYCLES(TURN_CYCLES)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .link_kill     (link_kill),
        .evt           (evt),
        .idx_d         (idx_d),
        .rx_pkt_start  (rx_pkt_start),
        .rx_pkt_end    (rx_pkt_end),
        .ep_stall      (ep_stall),
        .ep_iso        (ep_iso),
        .ep_has_data   (ep_has_data),
        .ep_data_done  (ep_data_done),
        .tog_q         (tog_q),
        .tx_data_get   (tx_data_get),
        .tx_pkt_end    (tx_pkt_end),
        .st            (st),
        .ep_idx        (buf_ep),
        .buf_addr      (buf_addr),
        .tx_start      (tx_start),
        .tx_pid        (tx_pid),
        .tx_data_avail (tx_data_avail),
        .ack_take      (ack_take)
    );

    fs_in_toggle_bank #(.NUM_EP(NUM_EP), .EP_IDX_W(EP_IDX_W)) u_tog (
        .clk        (clk),
        .rst        (rst),
        .link_reset (link_reset),
        .setup_hit  (setup_hit),
        .setup_idx  (idx_d),
        .ack_take   (ack_take),
        .ack_idx    (buf_ep),
        .tog_we     (tog_we),
        .tog_wdata  (tog_wdata),
        .tog_q      (tog_q),
        .in_sent    (in_sent)
    );

endmodule

// File: rtl/fs_in_engine_chk.sv
module fs_in_engine_chk
    import fs_in_pkg::*;
#(
    parameter int NUM_EP  = 4,
    parameter int BYTE_AW = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               link_reset,
    input logic               link_active,
    input logic               tx_start,
    input logic [3:0]         tx_pid,
    input logic               tx_data_get,
    input logic [BYTE_AW-1:0] buf_addr,
    input logic               tog_we,
    input logic [NUM_EP-1:0]  tog_q,
    input logic [NUM_EP-1:0]  in_sent,
    input xact_st_e           st
);

    a_r12_kill_to_idle: assert property (@(posedge clk) disable iff (rst)
        (link_reset || !link_active) |=> (st == ST_IDLE));

    a_r4_reply_pid: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> (tx_pid == PID_DATA0 || tx_pid == PID_DATA1 ||
                      tx_pid == PID_STALL || tx_pid == PID_NAK));

    a_r6_addr_clear: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |=> (buf_addr == '0));

    a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PAYLOAD && !tx_data_get) |=> $stable(buf_addr));

    a_r9_sent_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_sent));

    a_r9_sent_flips: assert property (@(posedge clk) disable iff (rst)
        ((|in_sent) && !$past(tog_we) && !$past(link_reset))
        |-> (tog_q != $past(tog_q)));

    a_r8_wait_exits: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HS_WAIT) |=> (st == ST_HS_WAIT || st == ST_HS_RECV || st == ST_IDLE));

endmodule

bind fs_in_engine fs_in_engine_chk #(.NUM_EP(NUM_EP), .BYTE_AW(BYTE_AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .link_reset  (link_reset),
    .link_active (link_active),
    .tx_start    (tx_start),
    .tx_pid      (tx_pid),
    .tx_data_get (tx_data_get),
    .buf_addr    (buf_addr),
    .tog_we      (tog_we),
    .tog_q       (tog_q),
    .in_sent     (in_sent),
    .st          (st)
);

// File: tb/fs_in_engine_test.sv
module fs_in_engine_test;
    import fs_in_pkg::*;

    localparam int NEP  = 4;
    localparam int BAW  = 3;
    localparam int TURN = 20;
    localparam logic [6:0] MYADDR = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_reset = 1'b0, link_active = 1'b1;
    logic rx_pkt_start = 1'b0, rx_pkt_end = 1'b0, rx_pkt_valid = 1'b0;
    logic [3:0] rx_pid = 4'h0, rx_endp = 4'h0;
    logic [6:0] rx_addr = 7'h0;
    logic [NEP-1:0] ep_enabled = 4'b1011, ep_stall = '0, ep_iso = '0;
    logic [NEP-1:0] ep_has_data = '0, ep_data_done = '0;
    logic tx_data_get = 1'b0, tx_pkt_end = 1'b0;
    logic tog_we = 1'b0;
    logic [NEP-1:0] tog_wdata = '0;
    logic tx_start, tx_data_avail;
    logic [3:0] tx_pid;
    logic [1:0] buf_ep;
    logic [BAW-1:0] buf_addr;
    logic [NEP-1:0] tog_q, in_sent;

    int checks = 0;
    int errors = 0;
    logic [NEP-1:0] exp_tog = '0;

    always #2 clk = ~clk;

    fs_in_engine #(.NUM_EP(NEP), .BYTE_AW(BAW), .TURN_CYCLES(TURN)) uut (
        .clk(clk), .rst(rst), .link_reset(link_reset), .link_active(link_active),
        .dev_addr(MYADDR), .rx_pkt_start(rx_pkt_start), .rx_pkt_end(rx_pkt_end),
        .rx_pkt_valid(rx_pkt_valid), .rx_pid(rx_pid), .rx_addr(rx_addr),
        .rx_endp(rx_endp), .ep_enabled(ep_enabled), .ep_stall(ep_stall),
        .ep_iso(ep_iso), .ep_has_data(ep_has_data), .ep_data_done(ep_data_done),
        .tx_data_get(tx_data_get), .tx_pkt_end(tx_pkt_end), .tx_start(tx_start),
        .tx_pid(tx_pid), .tx_data_avail(tx_data_avail), .buf_ep(buf_ep),
        .buf_addr(buf_addr), .tog_we(tog_we), .tog_wdata(tog_wdata),
        .tog_q(tog_q), .in_sent(in_sent)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_tok(input logic [3:0] pid, input logic [6:0] addr, input logic [3:0] ep);
        @(negedge clk);
        rx_pid = pid; rx_addr = addr; rx_endp = ep;
        rx_pkt_end = 1'b1; rx_pkt_valid = 1'b1;
        @(negedge clk);
        rx_pkt_end = 1'b0; rx_pkt_valid = 1'b0;
    endtask

    task automatic rx_begin();
        @(negedge clk); rx_pkt_start = 1'b1;
        @(negedge clk); rx_pkt_start = 1'b0;
    endtask

    // packet start, then ACK end; optional toggle write in the ACK cycle
    task automatic send_ack(input logic we, input logic [NEP-1:0] wd);
        @(negedge clk); rx_pkt_start = 1'b1;
        @(negedge clk); rx_pkt_start = 1'b0;
        rx_pid = PID_ACK; rx_pkt_end = 1'b1; rx_pkt_valid = 1'b1;
        tog_we = we; tog_wdata = wd;
        @(negedge clk);
        rx_pkt_end = 1'b0; rx_pkt_valid = 1'b0; tog_we = 1'b0;
    endtask

    task automatic get_byte();
        @(negedge clk); tx_data_get = 1'b1;
        @(negedge clk); tx_data_get = 1'b0;
    endtask

    task automatic pkt_done();
        @(negedge clk); tx_pkt_end = 1'b1;
        @(negedge clk); tx_pkt_end = 1'b0;
    endtask

    task automatic write_tog(input logic [NEP-1:0] v);
        @(negedge clk); tog_we = 1'b1; tog_wdata = v;
        @(negedge clk); tog_we = 1'b0;
        exp_tog = v;
    endtask

    task automatic count_starts(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_start) cnt++;
        end
    endtask

    task automatic t_reset();
        chk("R4 tx_start after reset", tx_start, 0);
        chk("R6 buf_addr after reset", buf_addr, 0);
        chk("R9 in_sent after reset", in_sent, 0);
        chk("R11 toggles after reset", tog_q, 0);
    endtask

    task automatic t_filter();
        int n;
        send_tok(PID_IN, 7'h15, 4'd1);
        count_starts(4, n); chk("R1 wrong address ignored", n, 0);
        @(negedge clk); rx_pid = PID_IN; rx_addr = MYADDR; rx_endp = 4'd1;
        rx_pkt_end = 1'b1; rx_pkt_valid = 1'b0;
        @(negedge clk); rx_pkt_end = 1'b0;
        count_starts(4, n); chk("R1 invalid packet ignored", n, 0);
        send_tok(PID_OUT, MYADDR, 4'd1);
        count_starts(4, n); chk("R2 OUT token ignored", n, 0);
        send_tok(PID_IN, MYADDR, 4'd2);
        count_starts(4, n); chk("R2 disabled endpoint ignored", n, 0);
        send_tok(PID_IN, MYADDR, 4'd9);
        count_starts(4, n); chk("R3 absent endpoint ignored", n, 0);
    endtask

    task automatic t_nak();
        send_tok(PID_IN, MYADDR, 4'd1);
        @(negedge clk);
        chk("R4 NAK start", tx_start, 1);
        chk("R4 NAK pid", tx_pid, PID_NAK);
        @(negedge clk);
        chk("R4 start is one cycle", tx_start, 0);
        pkt_done();
        send_ack(1'b0, '0);
        chk("R10 ACK after NAK no pulse", in_sent, 0);
        chk("R10 ACK after NAK toggles", tog_q, exp_tog);
    endtask

    task automatic t_stall();
        ep_stall[1] = 1'b1; ep_has_data[1] = 1'b1;
        send_tok(PID_IN, MYADDR, 4'd1);
        @(negedge clk);
        chk("R4 STALL start", tx_start, 1);
        chk("R4 STALL pid", tx_pid, PID_STALL);
        pkt_done();
        ep_stall[1] = 1'b0; ep_has_data[1] = 1'b0;
    endtask

    task automatic t_data(input logic [3:0] ep, input int nbytes);
        ep_has_data[ep] = 1'b1;
        send_tok(PID_IN, MYADDR, ep);
        @(negedge clk);
        chk("R4 data start", tx_start, 1);
        chk("R5 data pid", tx_pid, data_pid(exp_tog[ep]));
        chk("R7 bytes available", tx_data_avail, 1);
        chk("R6 byte address starts at zero", buf_addr, 0);
        for (int k = 1; k <= nbytes; k++) begin
            get_byte();
            chk("R6 byte address step", buf_addr, k);
        end
        ep_data_done[ep] = 1'b1;
        @(negedge clk);
        chk("R7 payload finished", tx_data_avail, 0);
        get_byte();
        chk("R7 address frozen after finish", buf_addr, nbytes);
        pkt_done();
        send_ack(1'b0, '0);
        exp_tog[ep] = ~exp_tog[ep];
        chk("R9 toggle flipped by ACK", tog_q, exp_tog);
        chk("R9 release pulse", in_sent, 1 << ep);
        @(negedge clk);
        chk("R9 release pulse one cycle", in_sent, 0);
        ep_data_done[ep] = 1'b0; ep_has_data[ep] = 1'b0;
    endtask

    task automatic t_wrap();
        ep_has_data[3] = 1'b1;
        send_tok(PID_IN, MYADDR, 4'd3);
        @(negedge clk);
        for (int k = 0; k < 7; k++) get_byte();
        chk("R7 at all-ones address", buf_addr, 7);
        chk("R7 still sending", tx_data_avail, 1);
        get_byte();
        chk("R7 ends at all-ones request", tx_data_avail, 0);
        get_byte();
        chk("R7 no step after wrap", buf_addr, 0);
        pkt_done();
        send_ack(1'b0, '0);
        exp_tog[3] = ~exp_tog[3];
        chk("R9 toggle after wrap ACK", tog_q, exp_tog);
        ep_has_data[3] = 1'b0;
    endtask

    task automatic t_timeout();
        ep_has_data[1] = 1'b1; ep_data_done[1] = 1'b1;
        send_tok(PID_IN, MYADDR, 4'd1);
        @(negedge clk);
        chk("R4 start before timeout", tx_start, 1);
        @(negedge clk);
        pkt_done();
        repeat (TURN + 4) @(negedge clk);
        send_ack(1'b0, '0);
        chk("R8 late ACK no pulse", in_sent, 0);
        chk("R8 late ACK toggles", tog_q, exp_tog);
        ep_has_data[1] = 1'b0; ep_data_done[1] = 1'b0;
    endtask

    task automatic t_retry();
        logic [3:0] first;
        ep_has_data[1] = 1'b1; ep_data_done[1] = 1'b1;
        send_tok(PID_IN, MYADDR, 4'd1);
        @(negedge clk);
        first = tx_pid;
        pkt_done();
        rx_begin();
        send_tok(PID_IN, MYADDR, 4'd1);
        @(negedge clk);
        chk("R13 retry start", tx_start, 1);
        chk("R13 retry same pid", tx_pid, first);
        pkt_done();
        send_ack(1'b0, '0);
        exp_tog[1] = ~exp_tog[1];
        chk("R9 ACK after retry", tog_q, exp_tog);
        ep_has_data[1] = 1'b0; ep_data_done[1] = 1'b0;
    endtask

    task automatic t_iso();
        ep_iso[0] = 1'b1; ep_stall[0] = 1'b1; ep_data_done[0] = 1'b1;
        send_tok(PID_IN, MYADDR, 4'd0);
        @(negedge clk);
        chk("R4 iso ignores stall", tx_pid, data_pid(exp_tog[0]));
        pkt_done();
        send_ack(1'b0, '0);
        chk("R10 iso ACK no pulse", in_sent, 0);
        chk("R10 iso toggles", tog_q, exp_tog);
        ep_iso[0] = 1'b0; ep_stall[0] = 1'b0; ep_data_done[0] = 1'b0;
    endtask

    task automatic t_setup();
        write_tog(4'b1111);
        chk("R11 software write", tog_q, 4'b1111);
        send_tok(PID_SETUP, MYADDR, 4'd9);
        @(negedge clk);
        chk("R3 SETUP absent endpoint", tog_q, 4'b1111);
        send_tok(PID_SETUP, 7'h11, 4'd1);
        @(negedge clk);
        chk("R1 SETUP wrong address", tog_q, 4'b1111);
        send_tok(PID_SETUP, MYADDR, 4'd1);
        exp_tog = 4'b1101;
        chk("R11 SETUP clears toggle", tog_q, exp_tog);
    endtask

    task automatic t_collide();
        ep_has_data[1] = 1'b1; ep_data_done[1] = 1'b1;
        send_tok(PID_IN, MYADDR, 4'd1);
        @(negedge clk);
        pkt_done();
        send_ack(1'b1, 4'b0100);
        exp_tog = 4'b0100;
        chk("R11 write beats ACK flip", tog_q, exp_tog);
        chk("R9 pulse despite write", in_sent, 4'b0010);
        ep_has_data[1] = 1'b0; ep_data_done[1] = 1'b0;
    endtask

    task automatic t_link();
        write_tog(4'b1011);
        ep_has_data[1] = 1'b1;
        send_tok(PID_IN, MYADDR, 4'd1);
        @(negedge clk);
        get_byte();
        @(negedge clk); link_reset = 1'b1;
        @(negedge clk); link_reset = 1'b0;
        exp_tog = '0;
        chk("R12 link reset clears toggles", tog_q, 0);
        chk("R12 link reset stops payload", tx_data_avail, 0);
        @(negedge clk);
        chk("R12 address cleared", buf_addr, 0);
        send_tok(PID_IN, MYADDR, 4'd1);
        @(negedge clk);
        get_byte();
        @(negedge clk); link_active = 1'b0;
        @(negedge clk);
        chk("R12 inactive link stops payload", tx_data_avail, 0);
        link_active = 1'b1;
        send_ack(1'b0, '0);
        chk("R12 ACK after abort ignored", in_sent, 0);
        ep_has_data[1] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_filter();
        t_nak();
        t_stall();
        t_data(4'd1, 3);
        t_data(4'd1, 2);
        t_wrap();
        t_timeout();
        t_retry();
        t_iso();
        t_setup();
        t_collide();
        t_link();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule